// File: doc/BRIEF.md
# Prioritized multi-port write memory

A synchronous word array shared by several write ports and several registered read ports, all in one clock domain. Each port is either narrow (one word per access) or wide, covering 2^k consecutive words in one access. A write port carries one enable bit for every data bit it carries. When several write ports touch the same bit in the same cycle, a compile-time priority mask decides which port prevails. The mask is resolved by gating the enables of the losing port against the winning port, word by word, so that wide and narrow ports compare correctly.

Internally every port is flattened into lanes of one word each. Sub-word s of a port forms one lane. The write buses are lane-packed: the port with index p starts at the lane equal to the sum of 2^k over all lower ports. Its sub-word s occupies bits [(base+s)*DATA_W +: DATA_W] of `wr_en` and `wr_data`. The read data bus is packed in the same way. On reset the array is loaded with a constant image assembled from address/data segments given as parameters.

Top module: `mpw_mem`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, the array is loaded with the initial image and every read data bit is cleared to 0, whatever the other inputs are.
- R2: Segment s of the initial image holds `SEG_LEN[s]` words, at most `SEG_WORDS`. Its word j is `SEG_DATA` bits [(s*SEG_WORDS+j)*DATA_W +: DATA_W] and goes to address `SEG_ADDR[s]`+j. A higher-numbered segment overrides a lower one. Words that fall outside [START_OFF, START_OFF+DEPTH) are dropped. Words that no segment covers are undefined.
- R3: If read port q has `rd_en[q]` high at a rising edge, its output afterwards holds, for each sub-word s, the word at address `rd_addr`+s (modulo 2^ADDR_W) as it was before that edge's writes. The word appears at bits [(base_q+s)*DATA_W +: DATA_W]. An address outside [START_OFF, START_OFF+DEPTH) reads as 0.
- R4: A read port whose `rd_en` bit is low at an edge keeps its output unchanged, even when that address is written in the same cycle.
- R5: A write changes only the bits whose enable bit is 1. Every other bit of the word keeps its value.
- R6: Sub-word s of a write port with 2^k words goes to address `wr_addr`+s. It uses the data and enable bits of lane base_p+s.
- R7: If bit h*NWR+l of `PRIO_MASK` is set (with h>l) and ports h and l both enable the same bit of the same word in one cycle, the stored bit equals port h's data. The default mask gives port 2 priority over ports 0 and 1.
- R8: If two ports enable the same bit in one cycle and neither has priority over the other, the stored bit is the OR of their data bits. In the default mask this is the pair of ports 0 and 1.
- R9: A write lane whose address lies outside [START_OFF, START_OFF+DEPTH) changes no word.
- R10: Priority removes only the bits that overlap. Bits that the lower port enables and the higher port does not are still written by the lower port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NWLANE*DATA_W | Per-bit write enables, lane packed |
| wr_addr | input | NWR*ADDR_W | Write address of port p at [p*ADDR_W +: ADDR_W] |
| wr_data | input | NWLANE*DATA_W | Write data, lane packed |
| rd_en | input | NRD | Read enable, one bit per read port |
| rd_addr | input | NRD*ADDR_W | Read address of port q at [q*ADDR_W +: ADDR_W] |
| rd_data | output | NRLANE*DATA_W | Registered read data, lane packed |

## Verification
The hard case is a collision between write ports, prioritized or not, that happens in the same cycle as a read of the word being written. The collision must resolve per bit according to the mask, and the read must return the value from before the write. Directed cycles aim a narrow port and a wide port at one word with partly overlapping enables, and read that word in the same cycle. Random cycles then cluster the addresses of all ports into a narrow window, so wide and narrow lanes overlap often. Every read result is judged bit by bit against a behavioural model of the array. The model applies the mask, the OR rule and the read-before-write order, and skips bits it knows to be undefined.

// File: rtl/mpw_pkg.sv
// Package: elaboration helpers shared by the memory modules.
// Port widths are packed as 2-bit log2 word counts in a vector; at most 32 ports.
package mpw_pkg;

    localparam int WL_BITS = 2;

    // Log2 word count of port idx taken from a packed width vector.
    function automatic int wl_at(input logic [63:0] vec, input int idx);
        return int'(vec[idx*WL_BITS +: WL_BITS]);
    endfunction

    // First lane index of port idx (equals total lane count when idx = port count).
    function automatic int lane_base(input logic [63:0] vec, input int idx);
        int acc;
        acc = 0;
        for (int i = 0; i < idx; i++) acc += (1 << wl_at(vec, i));
        return acc;
    endfunction

    // Port that owns a given lane.
    function automatic int lane_port(input logic [63:0] vec, input int nports, input int lane);
        int owner;
        owner = 0;
        for (int i = 0; i < nports; i++)
            if (lane >= lane_base(vec, i)) owner = i;
        return owner;
    endfunction

endpackage

// File: rtl/mpw_prio_gate.sv
// Priority gate: removes from each write lane the enable bits that a
// higher-priority lane also enables at the same word address.
// Assumes: all lanes share one clock; a pair is ranked only when the
// higher port index has its mask bit set over the lower one.
module mpw_prio_gate #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int NWR    = 3,
    parameter int NLANE  = 7,
    parameter logic [NWR*2-1:0]   WR_WL     = 6'b10_01_00,
    parameter logic [NWR*NWR-1:0] PRIO_MASK = 9'b011_000_000
) (
    input  logic [ADDR_W-1:0] lane_addr [NLANE],
    input  logic [DATA_W-1:0] lane_en   [NLANE],
    output logic [DATA_W-1:0] lane_en_g [NLANE]
);

    for (genvar a = 0; a < NLANE; a++) begin : g_lane
        localparam int PA = mpw_pkg::lane_port(64'(WR_WL), NWR, a);
        logic [DATA_W-1:0] kill;

        // Collect enables of higher-ranked lanes aimed at this lane's word.
        always_comb begin
            kill = '0;
            for (int b = 0; b < NLANE; b++) begin
                if (mpw_pkg::lane_port(64'(WR_WL), NWR, b) > PA &&
                    PRIO_MASK[mpw_pkg::lane_port(64'(WR_WL), NWR, b)*NWR + PA] &&
                    lane_addr[b] == lane_addr[a])
                    kill = kill | lane_en[b];
            end
        end

        // Keep only the bits no higher-ranked lane claims.
        assign lane_en_g[a] = lane_en[a] & ~kill;
    end

endmodule

// File: rtl/mpw_array.sv
// Word array: loads the constant segment image on reset and merges the
// gated write lanes each cycle (OR of enabled data, per bit).
// Assumes: START_OFF+DEPTH fits in ADDR_W bits; lanes with no word match are dropped.
module mpw_array #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int START_OFF = 16,
    parameter int ADDR_W    = 6,
    parameter int NLANE     = 7,
    parameter int NSEG      = 4,
    parameter int SEG_WORDS = 4,
    parameter logic [NSEG*ADDR_W-1:0] SEG_ADDR = {6'd30, 6'd21, 6'd20, 6'd14},
    parameter logic [NSEG*8-1:0]      SEG_LEN  = {8'd4, 8'd4, 8'd3, 8'd4},
    parameter logic [NSEG*SEG_WORDS*DATA_W-1:0] SEG_DATA =
        128'hD3D2D1D0_C3C2C1C0_B3B2B1B0_A3A2A1A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lane_addr [NLANE],
    input  logic [DATA_W-1:0] lane_en   [NLANE],
    input  logic [DATA_W-1:0] lane_data [NLANE],
    output logic [DATA_W-1:0] mem_q     [DEPTH]
);

    localparam int IMG_BITS = DEPTH * DATA_W;
    localparam int SEG_BITS = SEG_WORDS * DATA_W;

    // Builds the reset image: undefined by default, later segments win.
    function automatic logic [IMG_BITS-1:0] build_image();
        logic [IMG_BITS-1:0] img;
        int off;
        int nbits;
        img = 'x;
        for (int s = 0; s < NSEG; s++) begin
            off   = (int'(SEG_ADDR[s*ADDR_W +: ADDR_W]) - START_OFF) * DATA_W;
            nbits = int'(SEG_LEN[s*8 +: 8]) * DATA_W;
            for (int i = 0; i < SEG_BITS; i++)
                if (i < nbits && off + i >= 0 && off + i < IMG_BITS)
                    img[off + i] = SEG_DATA[s*SEG_BITS + i];
        end
        return img;
    endfunction

    localparam logic [IMG_BITS-1:0] INIT_IMG = build_image();

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(START_OFF + w);
        logic [DATA_W-1:0] hit_en;
        logic [DATA_W-1:0] hit_dat;

        // Gather every lane aimed at this word.
        always_comb begin
            hit_en  = '0;
            hit_dat = '0;
            for (int l = 0; l < NLANE; l++) begin
                if (lane_addr[l] == WADDR) begin
                    hit_en  = hit_en  | lane_en[l];
                    hit_dat = hit_dat | (lane_en[l] & lane_data[l]);
                end
            end
        end

        // Store the word: image on reset, merged write otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[w] <= INIT_IMG[w*DATA_W +: DATA_W];
            else
                mem_q[w] <= (mem_q[w] & ~hit_en) | hit_dat;
        end
    end

endmodule

// File: rtl/mpw_rd_port.sv
// Registered read port spanning 2^K words; captures the array contents
// present before the edge's writes. Out-of-range words read as 0.
module mpw_rd_port #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int START_OFF = 16,
    parameter int ADDR_W    = 6,
    parameter int K         = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      mem_q [DEPTH],
    output logic [(DATA_W<<K)-1:0] rd_q
);

    for (genvar s = 0; s < (1 << K); s++) begin : g_sub
        logic [ADDR_W-1:0] sub_addr;
        logic [DATA_W-1:0] sub_word;

        assign sub_addr = addr + ADDR_W'(s);

        // Select the addressed word, or 0 when outside the array.
        always_comb begin
            sub_word = '0;
            for (int w = 0; w < DEPTH; w++)
                if (sub_addr == ADDR_W'(START_OFF + w)) sub_word = mem_q[w];
        end

        // Register the sub-word on enable; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q[s*DATA_W +: DATA_W] <= '0;
            else if (en)
                rd_q[s*DATA_W +: DATA_W] <= sub_word;
        end
    end

endmodule

// File: rtl/mpw_mem.sv
// Top: prioritized multi-port write memory. Splits each write port into
// one-word lanes, gates the lanes by the priority mask, merges them into
// the array, and serves registered read ports.
// Assumes: one clock; START_OFF and DEPTH are multiples of the largest
// port word count; wide port addresses are aligned to their word count.
module mpw_mem #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int START_OFF = 16,
    parameter int ADDR_W    = 6,
    parameter int NWR       = 3,
    parameter int NRD       = 2,
    parameter logic [NWR*2-1:0]   WR_WL     = 6'b10_01_00,
    parameter logic [NRD*2-1:0]   RD_WL     = 4'b01_00,
    parameter logic [NWR*NWR-1:0] PRIO_MASK = 9'b011_000_000,
    parameter int NSEG      = 4,
    parameter int SEG_WORDS = 4,
    parameter logic [NSEG*ADDR_W-1:0] SEG_ADDR = {6'd30, 6'd21, 6'd20, 6'd14},
    parameter logic [NSEG*8-1:0]      SEG_LEN  = {8'd4, 8'd4, 8'd3, 8'd4},
    parameter logic [NSEG*SEG_WORDS*DATA_W-1:0] SEG_DATA =
        128'hD3D2D1D0_C3C2C1C0_B3B2B1B0_A3A2A1A0,
    localparam int NWLANE = mpw_pkg::lane_base(64'(WR_WL), NWR),
    localparam int NRLANE = mpw_pkg::lane_base(64'(RD_WL), NRD)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWLANE*DATA_W-1:0]   wr_en,
    input  logic [NWR*ADDR_W-1:0]      wr_addr,
    input  logic [NWLANE*DATA_W-1:0]   wr_data,
    input  logic [NRD-1:0]             rd_en,
    input  logic [NRD*ADDR_W-1:0]      rd_addr,
    output logic [NRLANE*DATA_W-1:0]   rd_data
);

    logic [ADDR_W-1:0] lane_addr [NWLANE];
    logic [DATA_W-1:0] lane_en   [NWLANE];
    logic [DATA_W-1:0] lane_data [NWLANE];
    logic [DATA_W-1:0] lane_en_g [NWLANE];
    logic [DATA_W-1:0] mem_q     [DEPTH];

    // Split every write port into one-word lanes.
    for (genvar p = 0; p < NWR; p++) begin : g_wport
        localparam int K    = mpw_pkg::wl_at(64'(WR_WL), p);
        localparam int BASE = mpw_pkg::lane_base(64'(WR_WL), p);
        for (genvar s = 0; s < (1 << K); s++) begin : g_sub
            assign lane_addr[BASE+s] = wr_addr[p*ADDR_W +: ADDR_W] + ADDR_W'(s);
            assign lane_en[BASE+s]   = wr_en[(BASE+s)*DATA_W +: DATA_W];
            assign lane_data[BASE+s] = wr_data[(BASE+s)*DATA_W +: DATA_W];
        end
    end

    mpw_prio_gate #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWR(NWR), .NLANE(NWLANE),
        .WR_WL(WR_WL), .PRIO_MASK(PRIO_MASK)
    ) u_gate (
        .lane_addr(lane_addr),
        .lane_en  (lane_en),
        .lane_en_g(lane_en_g)
    );

    mpw_array #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .START_OFF(START_OFF), .ADDR_W(ADDR_W),
        .NLANE(NWLANE), .NSEG(NSEG), .SEG_WORDS(SEG_WORDS),
        .SEG_ADDR(SEG_ADDR), .SEG_LEN(SEG_LEN), .SEG_DATA(SEG_DATA)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_addr(lane_addr),
        .lane_en  (lane_en_g),
        .lane_data(lane_data),
        .mem_q    (mem_q)
    );

    // One registered read port per index, packed by lane.
    for (genvar q = 0; q < NRD; q++) begin : g_rport
        localparam int K    = mpw_pkg::wl_at(64'(RD_WL), q);
        localparam int BASE = mpw_pkg::lane_base(64'(RD_WL), q);
        mpw_rd_port #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .START_OFF(START_OFF),
            .ADDR_W(ADDR_W), .K(K)
        ) u_rd (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (rd_en[q]),
            .addr (rd_addr[q*ADDR_W +: ADDR_W]),
            .mem_q(mem_q),
            .rd_q (rd_data[BASE*DATA_W +: (DATA_W << K)])
        );
    end

endmodule

// File: rtl/mpw_mem_chk.sv
// Checker for mpw_mem: reset clearing, read hold, and the enable-gating
// contract between the lane splitter and the priority gate.
module mpw_mem_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int NWR    = 3,
    parameter int NRD    = 2,
    parameter logic [NWR*2-1:0]   WR_WL     = 6'b10_01_00,
    parameter logic [NRD*2-1:0]   RD_WL     = 4'b01_00,
    parameter logic [NWR*NWR-1:0] PRIO_MASK = 9'b011_000_000,
    localparam int NWLANE = mpw_pkg::lane_base(64'(WR_WL), NWR),
    localparam int NRLANE = mpw_pkg::lane_base(64'(RD_WL), NRD)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NRD-1:0]           rd_en,
    input logic [NRLANE*DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0]        lane_addr [NWLANE],
    input logic [DATA_W-1:0]        lane_en   [NWLANE],
    input logic [DATA_W-1:0]        lane_en_g [NWLANE]
);

    // R1: first cycle after reset shows cleared read data.
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rd_data == '0);

    for (genvar q = 0; q < NRD; q++) begin : g_hold
        localparam int K    = mpw_pkg::wl_at(64'(RD_WL), q);
        localparam int BASE = mpw_pkg::lane_base(64'(RD_WL), q);
        // R4: a read port without enable keeps its output.
        a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(rd_en[q])) |->
                $stable(rd_data[BASE*DATA_W +: (DATA_W << K)]));
    end

    for (genvar a = 0; a < NWLANE; a++) begin : g_lo
        localparam int PA = mpw_pkg::lane_port(64'(WR_WL), NWR, a);
        // R5: gating never adds an enable bit.
        a_r5_gate_subset: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en_g[a] & ~lane_en[a]) == '0);
        for (genvar b = 0; b < NWLANE; b++) begin : g_hi
            localparam int PB = mpw_pkg::lane_port(64'(WR_WL), NWR, b);
            if (PB > PA && PRIO_MASK[PB*NWR + PA]) begin : g_ranked
                // R7: a ranked lower lane never keeps a bit the higher lane takes.
                a_r7_prio_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                    (lane_addr[a] == lane_addr[b]) |-> (lane_en_g[a] & lane_en[b]) == '0);
            end
        end
    end

endmodule

bind mpw_mem mpw_mem_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWR(NWR), .NRD(NRD),
    .WR_WL(WR_WL), .RD_WL(RD_WL), .PRIO_MASK(PRIO_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .lane_addr(lane_addr),
    .lane_en  (lane_en),
    .lane_en_g(lane_en_g)
);

// File: tb/mpw_mem_tb_top.sv
// Bench for mpw_mem with default parameters: directed corner cycles and
// seeded random colliding writes, judged against a behavioural model.
module mpw_mem_tb_top;

    localparam int W = 8, DEPTH = 16, START = 16, AW = 6, NWR = 3, NRD = 2;
    localparam int NWL = 7, NRL = 3;
    localparam int WWL [NWR] = '{0, 1, 2};
    localparam int WBASE [NWR] = '{0, 1, 3};
    localparam int RWL [NRD] = '{0, 1};
    localparam int RBASE [NRD] = '{0, 1};
    localparam int SEG_A [4] = '{14, 20, 21, 30};
    localparam int SEG_L [4] = '{4, 3, 4, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NWL*W-1:0] wr_en = '0, wr_data = '0;
    logic [NWR*AW-1:0] wr_addr = '0;
    logic [NRD-1:0] rd_en = '0;
    logic [NRD*AW-1:0] rd_addr = '0;
    logic [NRL*W-1:0] rd_data;

    always #2 clk = ~clk;

    mpw_mem dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    logic [W-1:0] m_val [DEPTH];
    logic [W-1:0] m_def [DEPTH];
    logic [NRL*W-1:0] e_val = '0, e_def = '1;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // R7: port 2 ranks over ports 0 and 1; ports 0 and 1 are unranked.
    function automatic bit ranks(input int hi, input int lo);
        return hi == 2 && lo < 2;
    endfunction

    // R1/R2: model of the reset image.
    task automatic model_reset();
        for (int w = 0; w < DEPTH; w++) begin m_val[w] = '0; m_def[w] = '0; end
        for (int s = 0; s < 4; s++)
            for (int j = 0; j < SEG_L[s]; j++) begin
                int idx = SEG_A[s] + j - START;
                if (idx >= 0 && idx < DEPTH) begin
                    m_val[idx] = {4'(4'hA + s), 4'(j)};
                    m_def[idx] = '1;
                end
            end
    endtask

    // R5-R10: per-bit write resolution of one cycle.
    task automatic model_write();
        logic [W-1:0] nv [DEPTH];
        logic [W-1:0] nd [DEPTH];
        for (int w = 0; w < DEPTH; w++) begin
            nv[w] = m_val[w]; nd[w] = m_def[w];
            for (int b = 0; b < W; b++) begin
                bit en_p [NWR];
                bit d_p [NWR];
                bit any = 0, v = 0;
                for (int p = 0; p < NWR; p++) begin
                    en_p[p] = 0; d_p[p] = 0;
                    for (int s = 0; s < (1 << WWL[p]); s++) begin
                        logic [AW-1:0] a = wr_addr[p*AW +: AW] + AW'(s);
                        if (int'(a) == START + w && wr_en[(WBASE[p]+s)*W + b]) begin
                            en_p[p] = 1; d_p[p] = wr_data[(WBASE[p]+s)*W + b];
                        end
                    end
                end
                for (int p = 0; p < NWR; p++) begin
                    bit killed = 0;
                    for (int h = p + 1; h < NWR; h++)
                        if (en_p[h] && ranks(h, p)) killed = 1;
                    if (en_p[p] && !killed) begin any = 1; v = v | d_p[p]; end
                end
                if (any) begin nv[w][b] = v; nd[w][b] = 1'b1; end
            end
        end
        for (int w = 0; w < DEPTH; w++) begin m_val[w] = nv[w]; m_def[w] = nd[w]; end
    endtask

    // One clock: predict reads (old contents), update model, compare.
    task automatic step(input string tag);
        if (!rst_n) begin
            e_val = '0; e_def = '1;
        end else begin
            for (int q = 0; q < NRD; q++)
                if (rd_en[q])
                    for (int s = 0; s < (1 << RWL[q]); s++) begin
                        logic [AW-1:0] a = rd_addr[q*AW +: AW] + AW'(s);
                        int idx = int'(a) - START;
                        if (idx >= 0 && idx < DEPTH) begin
                            e_val[(RBASE[q]+s)*W +: W] = m_val[idx];
                            e_def[(RBASE[q]+s)*W +: W] = m_def[idx];
                        end else begin
                            e_val[(RBASE[q]+s)*W +: W] = '0;
                            e_def[(RBASE[q]+s)*W +: W] = '1;
                        end
                    end
        end
        if (!rst_n) model_reset(); else model_write();
        @(posedge clk);
        @(negedge clk);
        for (int q = 0; q < NRD; q++) begin
            int lo = RBASE[q] * W;
            int nb = W << RWL[q];
            logic [NRL*W-1:0] msk = ((NRL*W)'(1) << nb) - 1;
            msk = (msk << lo) & e_def;
            n_chk++;
            if (((rd_data ^ e_val) & msk) != '0) begin
                n_bad++;
                $display("FAIL %s rd port %0d: actual %h expected %h (defined %h)",
                         tag, q, rd_data & msk, e_val & msk, msk);
            end
        end
    endtask

    task automatic idle();
        wr_en = '0; rd_en = '0;
    endtask

    task automatic wport(input int p, input int addr, input logic [31:0] en, input logic [31:0] dat);
        wr_addr[p*AW +: AW] = AW'(addr);
        for (int s = 0; s < (1 << WWL[p]); s++) begin
            wr_en[(WBASE[p]+s)*W +: W]   = en[s*W +: W];
            wr_data[(WBASE[p]+s)*W +: W] = dat[s*W +: W];
        end
    endtask

    task automatic rport(input int q, input int addr);
        rd_en[q] = 1'b1;
        rd_addr[q*AW +: AW] = AW'(addr);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        // R1: reset dominates reads and writes.
        rport(0, 20); rport(1, 16); wport(0, 20, 32'hFF, 32'h55);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1; idle();
        // R2: image placement, override, drop at both ends.
        rport(0, 16); rport(1, 20); step("R2 image lead/override");
        rport(0, 22); rport(1, 23); step("R2 image override");
        rport(0, 31); rport(1, 30); step("R2 image tail");
        rport(0, 17); rport(1, 31); step("R2 R3 image, out of range word");
        // Fill the whole array through the wide port.
        for (int i = 0; i < 4; i++) begin
            idle(); wport(2, START + 4*i, 32'hFFFF_FFFF, $urandom);
            step("R6 fill");
        end
        // R5: partial enable.
        idle(); wport(0, 18, 32'h0F, 32'hA5); step("R5 write");
        idle(); rport(0, 18); rport(1, 18); step("R5 partial enable");
        // R6: wide sub-word placement.
        idle(); wport(1, 20, 32'hFFFF, 32'hBEEF); wport(2, 24, 32'hFFFF_FFFF, 32'h4433_2211);
        step("R6 write");
        idle(); rport(0, 21); rport(1, 20); step("R6 wide2");
        idle(); rport(0, 27); rport(1, 24); step("R6 wide4");
        // R7/R10: ranked collision with partial overlap.
        idle(); wport(0, 24, 32'hFF, 32'hFF); wport(2, 24, 32'h0000_000F, 32'h0);
        step("R7 R10 write");
        idle(); rport(0, 24); step("R7 R10 ranked collision");
        // R8: unranked collision ORs data.
        idle(); wport(0, 26, 32'hFF, 32'h0F); wport(1, 26, 32'hFFFF, 32'h33F0);
        step("R8 write");
        idle(); rport(0, 26); rport(1, 26); step("R8 unranked collision");
        // R9: out-of-range writes leave the array alone.
        idle(); wport(0, 40, 32'hFF, 32'h5A); wport(1, 8, 32'hFFFF, 32'h3C3C);
        wport(2, 60, 32'hFFFF_FFFF, 32'h9999_9999);
        step("R9 write");
        idle(); rport(0, 24); rport(1, 16); step("R9 no aliasing");
        idle(); rport(0, 40); rport(1, 28); step("R9 R3 out of range");
        // R3: read before write in one cycle.
        idle(); wport(0, 19, 32'hFF, 32'h77); rport(0, 19); step("R3 read old");
        idle(); rport(0, 19); step("R3 read new");
        // R4: hold while the read address is written.
        idle(); wport(0, 19, 32'hFF, 32'h12); rd_addr[0 +: AW] = AW'(19); step("R4 hold");
        idle(); step("R4 hold");
        // Random colliding traffic across narrow and wide ports.
        for (int c = 0; c < 3000; c++) begin
            idle();
            for (int p = 0; p < NWR; p++)
                if ($urandom % 4 != 0) begin
                    int a = 14 + int'($urandom % 24);
                    a = a & ~((1 << WWL[p]) - 1);
                    wport(p, a, ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom, $urandom);
                end
            for (int q = 0; q < NRD; q++)
                if ($urandom % 3 != 0) begin
                    int a = 12 + int'($urandom % 28);
                    rport(q, a & ~((1 << RWL[q]) - 1));
                end
            step("R7 R8 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule